// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block produces the instantaneous divide value for a fractional synthesizer whose output frequency must be swept in a triangle. It takes a nominal divide value in fixed point (integer part above `FRAC`-free scaling chosen by the user; the block treats it as an unsigned number), a spread mode, an amplitude code, a rate select and an enable. Once per modulation period the divide value moves from its highest point, which is the lowest frequency, to its lowest point, which is the highest frequency, and back again. Because frequency is inverse to the divide ratio, all offsets are applied in divider space.

The sweep advances on a tick that is one clock in `TICK_DIV` of the reference clock. Each tick the accumulator adds or subtracts a fixed step, so the peak is reached after exactly one half period of ticks. In center mode the sweep is symmetric about the nominal value, so the average divide value equals the nominal. In down mode the smallest divide value equals the nominal, so the peak frequency equals the target and the average frequency lies below it. All settings are sampled only when a period begins, so a sweep in progress is never disturbed.

Top module: `ssm_profile_gen`

## Requirements
- R1: While reset is asserted and until the first tick after it, `div_out` is 0.
- R2: A tick occurs on every `TICK_DIV`-th rising clock edge after reset is released; `div_out` changes only in the cycle after a tick.
- R3: With `H = 2^HL_SLOW` ticks when `rate_fast` is 0 (slow rate, about 31 kHz) and `H = 2^HL_FAST` when it is 1 (fast rate, about 125 kHz), the step is `(nom_div * amp_code) >> (AMP_SHIFT + log2 H)`, the span is `step * H`, and the offset rises by one step for H ticks then falls by one step for H ticks, so one period is 2H ticks.
- R4: With `spread_down` = 0 (center) the output is `nom + span/2 - offset`; over one full period the divide values sum to `2H * nom`, so the average equals the nominal.
- R5: With `spread_down` = 1 (down) the output is `nom + span - offset`; it never falls below the nominal and equals it at mid period, so the peak frequency is the target.
- R6: With `spread_en` = 0 sampled at a period start, the generator stays idle and `div_out` equals the sampled nominal, re-sampled every tick.
- R7: A change of nominal, mode, amplitude, rate or enable during a period has no effect until the tick that starts the next period.
- R8: Each period begins at the lowest frequency: on the tick that starts a period the output is top minus one step, and the tick that ends it returns the output to the top value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nom_div | input | NOM_W | Nominal divide value, unsigned fixed point |
| spread_en | input | 1 | 1 enables the sweep, 0 holds the nominal |
| spread_down | input | 1 | 0 center spread, 1 down spread |
| amp_code | input | AMP_W | Span in units of nom/2^AMP_SHIFT |
| rate_fast | input | 1 | 0 slow modulation rate, 1 fast rate |
| div_out | output | NOM_W+1 | Instantaneous divide value |

## Verification
The tick that starts a new period does two things at once: it loads the new settings and it takes the first rising step with the freshly computed step size. This is provoked by changing amplitude, mode, rate and nominal in the middle of a sweep and again between the wrapping tick and the loading tick; it is judged by checking that the old sweep completes unchanged and that the first value of the next period equals the new top minus the new step, followed by a sweep of the new length.

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen #(
  parameter int NOM_W     = 24,
  parameter int AMP_W     = 7,
  parameter int AMP_SHIFT = 11,
  parameter int HL_SLOW   = 6,
  parameter int HL_FAST   = 4,
  parameter int TICK_DIV  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NOM_W-1:0] nom_div,
  input  logic             spread_en,
  input  logic             spread_down,
  input  logic [AMP_W-1:0] amp_code,
  input  logic             rate_fast,
  output logic [NOM_W:0]   div_out
);
  localparam int TW      = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PW      = HL_SLOW + 1;
  localparam int OW      = NOM_W + 1;
  localparam int PROD_W  = NOM_W + AMP_W;
  localparam int SH_SLOW = AMP_SHIFT + HL_SLOW;
  localparam int SH_FAST = AMP_SHIFT + HL_FAST;

  logic [TW-1:0]     tdiv;
  logic              tick;
  logic [PW-1:0]     pos;
  logic [OW-1:0]     tri_acc;
  logic [NOM_W-1:0]  nom_q, step_q, step_new;
  logic              en_q, down_q, fast_q;
  logic [PROD_W-1:0] prod;
  logic [PW-1:0]     half, last;
  logic [OW-1:0]     span, base;
  logic              rising;

  assign tick     = (tdiv == TW'(TICK_DIV - 1));
  assign prod     = PROD_W'(nom_div) * PROD_W'(amp_code);
  assign step_new = NOM_W'(prod >> (rate_fast ? SH_FAST : SH_SLOW));
  assign half     = fast_q ? PW'(1 << HL_FAST) : PW'(1 << HL_SLOW);
  assign last     = fast_q ? PW'((1 << (HL_FAST + 1)) - 1) : PW'((1 << (HL_SLOW + 1)) - 1);
  assign span     = fast_q ? (OW'(step_q) << HL_FAST) : (OW'(step_q) << HL_SLOW);
  assign rising   = (pos < half);
  assign base     = down_q ? (OW'(nom_q) + span) : (OW'(nom_q) + (span >> 1));
  assign div_out  = en_q ? (base - tri_acc) : OW'(nom_q);

  always_ff @(posedge clk) begin
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tick ? '0 : tdiv + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      tri_acc <= '0;
      nom_q   <= '0;
      step_q  <= '0;
      en_q    <= 1'b0;
      down_q  <= 1'b0;
      fast_q  <= 1'b0;
    end else if (tick) begin
      if (pos == '0) begin
        nom_q  <= nom_div;
        en_q   <= spread_en;
        down_q <= spread_down;
        fast_q <= rate_fast;
        step_q <= step_new;
        if (spread_en) begin
          pos     <= PW'(1);
          tri_acc <= OW'(step_new);
        end else begin
          pos     <= '0;
          tri_acc <= '0;
        end
      end else begin
        pos     <= (pos == last) ? '0 : pos + 1'b1;
        tri_acc <= rising ? (tri_acc + OW'(step_q)) : (tri_acc - OW'(step_q));
      end
    end
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_hold_settings_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != '0) |=> ($stable(step_q) && $stable(nom_q) && $stable(down_q) &&
                     $stable(fast_q) && $stable(en_q)));

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && pos == '0) |-> (tri_acc == '0));

  assert_peak_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && pos == half) |-> (tri_acc == span));

  assert_center_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !down_q) |-> ((div_out <= OW'(nom_q) + (span >> 1)) &&
                           (div_out + (span >> 1) >= OW'(nom_q))));

  assert_down_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && down_q) |-> (div_out >= OW'(nom_q)));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pos == '0 && tri_acc == '0 && div_out == OW'(nom_q)));
endmodule

// File: tb/ssm_profile_gen_tb_top.sv
module ssm_profile_gen_tb_top;
  localparam int NOM_W = 24;
  localparam int TDIV  = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NOM_W-1:0] nom_div = '0;
  logic             spread_en = 1'b0;
  logic             spread_down = 1'b0;
  logic [6:0]       amp_code = '0;
  logic             rate_fast = 1'b0;
  logic [NOM_W:0]   div_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  ssm_profile_gen dut_i (
    .clk(clk), .rst_n(rst_n), .nom_div(nom_div), .spread_en(spread_en),
    .spread_down(spread_down), .amp_code(amp_code), .rate_fast(rate_fast),
    .div_out(div_out)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint hcnt(input bit fast);
    return fast ? 16 : 64;
  endfunction

  function automatic longint f_step(input longint nom, input longint amp, input bit fast);
    return (nom * amp) >> (11 + (fast ? 4 : 6));
  endfunction

  function automatic longint f_exp(input longint nom, input longint amp, input bit down,
                                   input bit fast, input longint p);
    longint h, st, sp, cnt, top;
    h   = hcnt(fast);
    st  = f_step(nom, amp, fast);
    sp  = st * h;
    cnt = (p <= h) ? p : 2 * h - p;
    top = down ? nom + sp : nom + sp / 2;
    return top - st * cnt;
  endfunction

  task automatic next_tick();
    repeat (TDIV) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input longint nom, input bit en, input bit down,
                          input longint amp, input bit fast);
    rst_n = 1'b0;
    nom_div = NOM_W'(nom); spread_en = en; spread_down = down;
    amp_code = 7'(amp); rate_fast = fast;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_idle_r1_r2_r6();
    do_reset(51200, 1'b0, 1'b0, 40, 1'b0);
    chk("R1 reset value", div_out, 0);
    repeat (TDIV - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 no change before tick", div_out, 0);
    @(posedge clk); @(negedge clk);
    chk("R6 idle holds nominal", div_out, 51200);
    nom_div = 24'd30000;
    repeat (TDIV - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 nominal change waits for tick", div_out, 51200);
    @(posedge clk); @(negedge clk);
    chk("R6 idle follows nominal", div_out, 30000);
    amp_code = 7'd100; spread_down = 1'b1;
    next_tick();
    chk("R6 amplitude ignored when off", div_out, 30000);
  endtask

  task automatic t_sweep_r3(input longint nom, input bit down, input longint amp, input bit fast);
    longint h, sum, mn, mx;
    h = hcnt(fast);
    sum = 0; mn = 64'h7fffffff; mx = 0;
    do_reset(nom, 1'b1, down, amp, fast);
    for (int k = 1; k <= 2 * h; k++) begin
      next_tick();
      chk("R3 triangle value", div_out, f_exp(nom, amp, down, fast, k % (2 * h)));
      sum += longint'(div_out);
      if (longint'(div_out) < mn) mn = longint'(div_out);
      if (longint'(div_out) > mx) mx = longint'(div_out);
      if (k == 1)
        chk("R8 first tick is top minus step", div_out,
            f_exp(nom, amp, down, fast, 0) - f_step(nom, amp, fast));
      if (k == 2 * h)
        chk("R8 period ends at top", div_out, f_exp(nom, amp, down, fast, 0));
    end
    chk("R3 peak-to-peak equals span", mx - mn, f_step(nom, amp, fast) * h);
    if (down) begin
      chk("R5 minimum divide equals nominal", mn, nom);
    end else begin
      chk("R4 period average equals nominal", sum, 2 * h * nom);
    end
  endtask

  task automatic t_midchange_r7();
    longint h, h2;
    h = hcnt(1'b1); h2 = hcnt(1'b0);
    do_reset(51200, 1'b1, 1'b0, 41, 1'b1);
    for (int k = 1; k <= 2 * h; k++) begin
      next_tick();
      if (k == h / 2) begin
        nom_div = 24'd40000; amp_code = 7'd90; spread_down = 1'b1; rate_fast = 1'b0;
      end
      chk("R7 old sweep unchanged", div_out, f_exp(51200, 41, 1'b0, 1'b1, k % (2 * h)));
    end
    for (int k = 1; k <= h2 + 2; k++) begin
      next_tick();
      chk("R7 new settings from next period", div_out, f_exp(40000, 90, 1'b1, 1'b0, k));
    end
  endtask

  task automatic t_disable_r6_r7();
    longint h;
    h = hcnt(1'b1);
    do_reset(60000, 1'b1, 1'b1, 70, 1'b1);
    for (int k = 1; k <= 2 * h; k++) begin
      next_tick();
      if (k == 3) begin
        spread_en = 1'b0; nom_div = 24'd45000;
      end
      chk("R7 disable waits for period end", div_out, f_exp(60000, 70, 1'b1, 1'b1, k % (2 * h)));
    end
    next_tick();
    chk("R6 disabled output is nominal", div_out, 45000);
    next_tick();
    chk("R6 stays idle", div_out, 45000);
    spread_en = 1'b1; spread_down = 1'b0; amp_code = 7'd20;
    next_tick();
    chk("R8 re-enable starts at top minus step", div_out,
        f_exp(45000, 20, 1'b0, 1'b1, 1));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_idle_r1_r2_r6();
    t_sweep_r3(51200, 1'b0, 41, 1'b0);
    t_sweep_r3(51200, 1'b1, 82, 1'b0);
    t_sweep_r3(25728, 1'b1, 82, 1'b1);
    t_sweep_r3(3000000, 1'b0, 5, 1'b1);
    t_sweep_r3(51200, 1'b0, 127, 1'b1);
    t_midchange_r7();
    t_disable_r6_r7();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule